// File: doc/BRIEF.md
# Timer Compare Output Unit

This block is one compare channel with its own 16-bit time base. While the counter runs, the channel tests it against a programmable compare value. On the first cycle of equality, the channel carries out the action chosen by a 4-bit mode code:

- drive its private output latch high;
- drive the latch low;
- toggle the latch;
- only raise an interrupt flag;
- emit a special trigger, which clears the counter so that the compare value acts as a period.

When the trigger build option is on, the trigger can also send a start pulse to a converter, but only while a converter-enable input is high.

Software uses a small write port:

- Address 0 loads the compare value.
- Address 1 loads the control word. Bits [3:0] hold the mode and bit 4 enables the interrupt.
- Address 2 is a strobe. Any write to it clears the interrupt flag.

The output latch belongs to this channel alone. Pin direction logic is outside the block.

Top module: `cmp_out_unit`

## Requirements
- R1: After a synchronous reset, the timer, compare value, control word, output latch, interrupt flag, interrupt, timer-clear pulse and converter-start pulse all read zero.
- R2: A match is the equality of all 16 timer bits with the compare value. Only the first cycle of an equality acts. While the timer stays on that value, no further action follows.
- R3: Each mode acts on the latch at the clock edge that ends the first cycle of a match. Mode 1000 sets the latch to 1, mode 1001 clears it to 0, and mode 0010 inverts it.
- R4: A match in any of the modes 0010, 1000, 1001, 1010 or 1011 sets the interrupt flag. The flag stays set until a write to address 2. When a match and that write fall in the same cycle, the set wins.
- R5: The interrupt output is high exactly when the flag and control bit 4 are both 1.
- R6: In mode 1011, a match produces a one-cycle timer-clear pulse. The timer reads zero in the cycle after that pulse.
- R7: The converter-start pulse occurs only together with the timer-clear pulse. It requires that the converter enable was high in the cycle of the match.
- R8: In mode 1010, a match leaves the latch unchanged.
- R9: Writing zero to control bits [4:0] forces the latch to 0. Writing mode 1000 initialises the latch to 0, and writing mode 1001 initialises it to 1. Every other code disables compare: it neither changes the latch nor sets the flag. A control write with one of these three latch values overrides a match action in the same cycle.
- R10: The timer advances by one, wrapping at 16 bits, in each cycle where the tick enable is high. It holds its value otherwise, unless a timer-clear pulse is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Timer increment enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 compare value, 1 control word, 2 flag clear |
| wr_data | input | 16 | Write data |
| conv_en | input | 1 | Converter enabled, gates the start pulse |
| timer_val | output | 16 | Current timer value |
| cmp_pin | output | 1 | Compare output latch |
| irq_flag | output | 1 | Sticky interrupt flag |
| irq | output | 1 | Flag gated by the interrupt enable |
| tmr_clr_pulse | output | 1 | One-cycle special trigger, clears the timer |
| conv_start | output | 1 | One-cycle converter start request |

## Verification
The assertions check the following on every cycle:

- the timer is zero after each clear pulse;
- the clear and start pulses last one cycle;
- the start pulse never occurs without the clear pulse;
- the flag holds until a clear strobe;
- the interrupt implies the flag;
- the timer holds when idle;
- a zero control write lowers the latch.

Some behaviours need the bench's scenarios and reference model:

- which mode drives the latch which way;
- the single firing while the timer sits on the compare value;
- the initial latch value set by a mode write;
- interrupt-only matches that leave the latch alone.

// File: rtl/cmpu_pkg.sv
package cmpu_pkg;
  typedef enum logic [3:0] {
    MD_OFF    = 4'b0000,
    MD_TOGGLE = 4'b0010,
    MD_SET    = 4'b1000,
    MD_CLR    = 4'b1001,
    MD_IRQ    = 4'b1010,
    MD_TRIG   = 4'b1011
  } cmp_mode_e;

  localparam int ADDR_CMP  = 0;
  localparam int ADDR_CTRL = 1;
  localparam int ADDR_ACK  = 2;

  function automatic logic mode_active(input logic [3:0] m);
    return (m == MD_TOGGLE) || (m == MD_SET) || (m == MD_CLR) ||
           (m == MD_IRQ) || (m == MD_TRIG);
  endfunction
endpackage

// File: rtl/cmpu_timer.sv
module cmpu_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          clr,
  output logic [TW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cmpu_match.sv
module cmpu_match #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] cnt,
  input  logic [TW-1:0] cmpv,
  input  logic          enable,
  output logic          hit
);
  logic eq_now;
  logic eq_q;

  assign eq_now = (cnt == cmpv);

  always_ff @(posedge clk) begin
    if (rst) eq_q <= 1'b0;
    else     eq_q <= eq_now;
  end

  assign hit = enable && eq_now && !eq_q;
endmodule

// File: rtl/cmpu_action.sv
module cmpu_action
  import cmpu_pkg::*;
#(
  parameter bit HAS_CONV = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] mode,
  input  logic       hit,
  input  logic       ctrl_wr,
  input  logic [4:0] ctrl_data,
  input  logic       flag_clr,
  input  logic       conv_en,
  output logic       pin,
  output logic       flag,
  output logic       trig,
  output logic       conv
);
  logic trig_hit;
  assign trig_hit = hit && (mode == MD_TRIG);

  always_ff @(posedge clk) begin
    if (rst) begin
      pin  <= 1'b0;
      flag <= 1'b0;
      trig <= 1'b0;
    end else begin
      trig <= trig_hit;
      if (hit)           flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
      if (ctrl_wr && (ctrl_data == 5'd0 || ctrl_data[3:0] == MD_SET))
        pin <= 1'b0;
      else if (ctrl_wr && ctrl_data[3:0] == MD_CLR)
        pin <= 1'b1;
      else if (hit) begin
        case (mode)
          MD_SET:    pin <= 1'b1;
          MD_CLR:    pin <= 1'b0;
          MD_TOGGLE: pin <= ~pin;
          default:   pin <= pin;
        endcase
      end
    end
  end

  generate
    if (HAS_CONV) begin : g_conv
      always_ff @(posedge clk) begin
        if (rst) conv <= 1'b0;
        else     conv <= trig_hit && conv_en;
      end
    end else begin : g_noconv
      assign conv = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/cmp_out_unit.sv
module cmp_out_unit
  import cmpu_pkg::*;
#(
  parameter int TW       = 16,
  parameter int AW       = 2,
  parameter bit HAS_CONV = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_en,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [TW-1:0] wr_data,
  input  logic          conv_en,
  output logic [TW-1:0] timer_val,
  output logic          cmp_pin,
  output logic          irq_flag,
  output logic          irq,
  output logic          tmr_clr_pulse,
  output logic          conv_start
);
  localparam int CTRL_W = 5;

  logic [TW-1:0] cmp_q;
  logic [3:0]    mode_q;
  logic          ien_q;
  logic          ctrl_wr, ack_wr, hit;

  assign ctrl_wr = wr_en && (wr_addr == AW'(ADDR_CTRL));
  assign ack_wr  = wr_en && (wr_addr == AW'(ADDR_ACK));

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q  <= '0;
      mode_q <= MD_OFF;
      ien_q  <= 1'b0;
    end else if (wr_en) begin
      if (wr_addr == AW'(ADDR_CMP)) cmp_q <= wr_data;
      if (ctrl_wr) begin
        mode_q <= wr_data[3:0];
        ien_q  <= wr_data[4];
      end
    end
  end

  cmpu_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst(rst), .tick(tick_en), .clr(tmr_clr_pulse), .cnt(timer_val)
  );

  cmpu_match #(.TW(TW)) u_match (
    .clk(clk), .rst(rst), .cnt(timer_val), .cmpv(cmp_q),
    .enable(mode_active(mode_q)), .hit(hit)
  );

  cmpu_action #(.HAS_CONV(HAS_CONV)) u_action (
    .clk(clk), .rst(rst), .mode(mode_q), .hit(hit), .ctrl_wr(ctrl_wr),
    .ctrl_data(wr_data[CTRL_W-1:0]), .flag_clr(ack_wr), .conv_en(conv_en),
    .pin(cmp_pin), .flag(irq_flag), .trig(tmr_clr_pulse), .conv(conv_start)
  );

  assign irq = irq_flag && ien_q;
endmodule

// File: rtl/cmpu_chk.sv
module cmpu_chk #(
  parameter int TW = 16,
  parameter int AW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          tick_en,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [TW-1:0] wr_data,
  input logic          conv_en,
  input logic [TW-1:0] timer_val,
  input logic          cmp_pin,
  input logic          irq_flag,
  input logic          irq,
  input logic          tmr_clr_pulse,
  input logic          conv_start
);
  assert_clear_zero_R6: assert property (@(posedge clk) disable iff (rst)
    tmr_clr_pulse |=> timer_val == '0);
  assert_clear_single_R6: assert property (@(posedge clk) disable iff (rst)
    tmr_clr_pulse |=> !tmr_clr_pulse);
  assert_conv_with_trig_R7: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> tmr_clr_pulse);
  assert_conv_single_R7: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);
  assert_irq_needs_flag_R5: assert property (@(posedge clk) disable iff (rst)
    irq |-> irq_flag);
  assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    (irq_flag && !(wr_en && wr_addr == AW'(2))) |=> irq_flag);
  assert_timer_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!tmr_clr_pulse && !tick_en) |=> timer_val == $past(timer_val));
  assert_zero_ctrl_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == AW'(1) && wr_data[4:0] == 5'd0) |=> !cmp_pin);
endmodule

bind cmp_out_unit cmpu_chk #(.TW(TW), .AW(AW)) u_chk (.*);

// File: tb/test_cmp_out_unit.sv
module test_cmp_out_unit;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 16;

  logic clk = 1'b0;
  logic rst, tick_en, wr_en, conv_en;
  logic [1:0] wr_addr;
  logic [TW-1:0] wr_data, timer_val;
  logic cmp_pin, irq_flag, irq, tmr_clr_pulse, conv_start;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  logic [TW-1:0] m_cnt, m_cmp;
  logic [3:0] m_mode;
  logic m_ien, m_pin, m_flag, m_trst, m_conv, m_prev;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_out_unit i_cmp_out_unit (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .conv_en(conv_en), .timer_val(timer_val),
    .cmp_pin(cmp_pin), .irq_flag(irq_flag), .irq(irq),
    .tmr_clr_pulse(tmr_clr_pulse), .conv_start(conv_start)
  );

  function automatic bit is_cmp_mode(input logic [3:0] m);
    return m == 4'b0010 || m == 4'b1000 || m == 4'b1001 || m == 4'b1010 || m == 4'b1011;
  endfunction

  task automatic chk1(input logic act, input logic exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    n_run++;
    if (timer_val !== m_cnt) begin
      n_fail++;
      $display("FAIL R10/R6 timer actual=%0d expected=%0d at %0t", timer_val, m_cnt, $time);
    end
    chk1(cmp_pin, m_pin, "R3/R8/R9 latch");
    chk1(irq_flag, m_flag, "R4 flag");
    chk1(irq, m_flag & m_ien, "R5 irq");
    chk1(tmr_clr_pulse, m_trst, "R6 clear pulse");
    chk1(conv_start, m_conv, "R7 start pulse");
  endtask

  // one cycle: check current outputs, drive inputs, advance the model
  task automatic step(input logic tk, input logic we, input logic [1:0] ad,
                      input logic [TW-1:0] dt, input logic ce);
    logic match, hit, cw;
    @(negedge clk);
    compare_all();
    tick_en = tk; wr_en = we; wr_addr = ad; wr_data = dt; conv_en = ce;
    match = (m_cnt == m_cmp);
    hit = is_cmp_mode(m_mode) && match && !m_prev;      // R2
    cw = we && ad == 2'd1;
    m_prev = match;
    m_cnt = m_trst ? '0 : (tk ? m_cnt + 1'b1 : m_cnt);
    m_conv = hit && m_mode == 4'b1011 && ce;
    m_trst = hit && m_mode == 4'b1011;
    if (hit) m_flag = 1'b1;
    else if (we && ad == 2'd2) m_flag = 1'b0;
    if (cw && (dt[4:0] == 5'd0 || dt[3:0] == 4'b1000)) m_pin = 1'b0;
    else if (cw && dt[3:0] == 4'b1001) m_pin = 1'b1;
    else if (hit) begin
      if (m_mode == 4'b1000) m_pin = 1'b1;
      else if (m_mode == 4'b1001) m_pin = 1'b0;
      else if (m_mode == 4'b0010) m_pin = ~m_pin;
    end
    if (we && ad == 2'd0) m_cmp = dt;
    if (cw) begin m_mode = dt[3:0]; m_ien = dt[4]; end
  endtask

  task automatic idle(input int n, input logic tk);
    for (int i = 0; i < n; i++) step(tk, 1'b0, 2'd0, '0, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [3:0] codes [7];
    codes = '{4'b0000, 4'b0010, 4'b1000, 4'b1001, 4'b1010, 4'b1011, 4'b0101};
    void'($urandom(32'd1234));
    rst = 1'b1; tick_en = 0; wr_en = 0; wr_addr = 0; wr_data = 0; conv_en = 0;
    m_cnt = 0; m_cmp = 0; m_mode = 0; m_ien = 0; m_pin = 0; m_flag = 0;
    m_trst = 0; m_conv = 0; m_prev = 0;
    repeat (3) @(negedge clk);
    compare_all();                                     // R1 reset state
    @(negedge clk); rst = 1'b0;
    // model: after reset cmp=0 and timer=0, so prev match is true
    m_prev = 1'b1;
    // R3: set mode with a visible rising edge
    step(0, 1, 2'd0, 16'd5, 0);
    step(0, 1, 2'd1, 16'h0018, 0);                     // ien=1 mode 1000
    idle(8, 1);
    // R2: timer holds on the compare value, no re-fire
    step(0, 1, 2'd2, 0, 0);
    step(0, 1, 2'd0, m_cnt + 16'd2, 0);
    idle(2, 1); idle(6, 0);
    chk1(irq_flag, 1'b1, "R2 single hit sets flag");
    step(0, 1, 2'd2, 0, 0); idle(4, 0);
    chk1(irq_flag, 1'b0, "R2 no re-fire while held");
    // R3 clear and toggle
    step(0, 1, 2'd1, 16'h0009, 0);
    step(0, 1, 2'd0, m_cnt + 16'd3, 0); idle(6, 1);
    step(0, 1, 2'd1, 16'h0002, 0);
    step(0, 1, 2'd0, m_cnt + 16'd2, 0); idle(5, 1);
    // R8 interrupt only
    step(0, 1, 2'd1, 16'h001A, 0);
    step(0, 1, 2'd0, m_cnt + 16'd2, 0); idle(5, 1);
    // R6/R7 trigger, converter on then off
    step(0, 1, 2'd1, 16'h000B, 1);
    step(0, 1, 2'd0, m_cnt + 16'd4, 1);
    for (int i = 0; i < 20; i++) step(1, 0, 2'd0, 0, 1);
    for (int i = 0; i < 20; i++) step(1, 0, 2'd0, 0, 0);
    // R9 zero write and disabled code
    step(0, 1, 2'd1, 16'h0000, 0);
    step(0, 1, 2'd1, 16'h0005, 0);
    step(0, 1, 2'd0, m_cnt + 16'd1, 0); idle(4, 1);
    // random phase
    for (int i = 0; i < 6000; i++) begin
      int r = $urandom % 10;
      logic [TW-1:0] d;
      if (r == 0)      d = m_cnt + 16'($urandom % 8);
      else if (r == 1) d = {11'd0, 1'($urandom), codes[$urandom % 7]};
      else             d = 16'($urandom);
      if (r < 3)
        step(1'($urandom), 1, (r == 0) ? 2'd0 : (r == 1) ? 2'd1 : 2'd2, d, 1'($urandom));
      else
        step(($urandom % 4) != 0, 0, 2'd0, d, 1'($urandom));
    end
    @(negedge clk);
    compare_all();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule